// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable single-port synchronous SRAM whose pipeline lets a read and a write follow each other on back-to-back clock cycles without any idle bus cycle. An operation is launched by presenting an address and a command on one rising edge. The data that belongs to it moves on the data buses exactly two enabled edges later. For a write, the data input is sampled on that edge. For a read, the registered data output is loaded on that edge. Because both directions use the same two-cycle offset, a host can mix reads and writes freely at full bus rate.

The word is split into 9-bit byte lanes (18 or 36 bits), and each lane has its own active-low write enable. A separate burst address generator turns a loaded address into a four-beat sequence, wrapping on the two low address bits, in linear or interleaved order. A hold input freezes the whole block. Three chip selects gate new operations. The data output is not a real tristate pad; its drive is signalled by a flag, which an asynchronous output-enable input can force low at any time.

Top module: `zbt_sram`

## Requirements
- R1: A read launched on an enabled edge (adv=0, all selects active, is_read=1) produces its word on rdata with rdata_drv high after the second enabled edge that follows the command edge.
- R2: A write launched on an enabled edge (is_read=0) takes wdata on the second enabled edge after the command, and a later read of that address returns it.
- R3: Reads and writes may alternate on consecutive edges with no idle cycle, and each write lands at its own address even when reads to other addresses were issued in between.
- R4: While hold is 1, every other input is ignored, and rdata, rdata_drv and all pipeline state stay unchanged; the pipeline continues where it left off once hold returns to 0.
- R5: On a load edge (adv=0), a new operation starts only if sel0_n=0, sel1=1 and sel2_n=0 all hold. Otherwise nothing starts and any burst in progress ends. Operations already in the pipeline still complete.
- R6: rdata_drv is low after the second enabled edge following a deselected load edge or a write command.
- R7: Lane i is bits [9i+8:9i] and is written only if lane_wr_n[i] is 0. The lane enables are sampled on the command edge of every write beat, loads and burst advances alike.
- R8: When is_read=1, lane_wr_n has no effect and memory is left unchanged.
- R9: out_en_n=1 forces rdata_drv low at once, without a clock edge, and does not disturb the pipeline.
- R10: A read issued on the edge right after a write to the same address returns the newly written lanes merged with the old contents of the lanes that were not written.
- R11: With adv=1 during an active burst, the next beat repeats the burst's read/write type. It keeps the upper address bits, and its low two bits are start+k mod 4 (linear, the default) or start XOR k (interleaved), with k counting beats 1, 2, 3, 0, and so on.
- R12: adv=1 when no burst is active starts no operation.
- R13: After reset the pipeline holds no valid operation and rdata_drv is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | 1 freezes the block for this edge |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new address, 1 advances the burst |
| is_read | input | 1 | 1 read, 0 write (sampled on load) |
| lane_wr_n | input | WORD/9 | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | WORD | Write data, two enabled edges after its command |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | WORD | Registered read data |
| rdata_drv | output | 1 | Output drive flag |

## Verification
The hardest case to reach from the ports is a read that is evaluated on the very edge where a partially masked write is still sitting in the write buffer and has not yet been committed. In that case the answer must be merged lane by lane. The stimulus table reaches it by issuing a full write, then a partial-lane write to the same address, then reads on the following edges. The table also runs a burst write whose last beat is read back as the first beat of an immediately following burst read. Directed steps afterwards freeze the pipeline with a write pending in the hold window, and they also exercise each chip select on its own.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  localparam int unsigned LANE_W = 9;

  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;

  // Low two address bits of burst beat k, counted from the loaded start.
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       linear);
    logic [1:0] sum;
    sum = start + beat;
    return linear ? sum : (start ^ beat);
  endfunction

endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter bit          LINEAR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              sel,
  input  logic              adv,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] addr,
  output logic              iss_valid,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr
);

  logic              act_q, act_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d, beat_nx;

  // next state and issued command
  always_comb begin
    beat_nx = beat_q + 2'd1;
    act_d   = act_q;
    op_d    = op_q;
    base_d  = base_q;
    beat_d  = beat_q;
    if (!adv) begin
      iss_valid = sel;
      iss_op    = is_read ? OP_RD : OP_WR;
      iss_addr  = addr;
      act_d     = sel;
      op_d      = is_read ? OP_RD : OP_WR;
      base_d    = addr;
      beat_d    = 2'd0;
    end else begin
      iss_valid = act_q;
      iss_op    = op_q;
      iss_addr  = {base_q[ADDR_W-1:2], beat_lsb(base_q[1:0], beat_nx, LINEAR)};
      beat_d    = beat_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      op_q   <= OP_RD;
      beat_q <= 2'd0;
    end else if (!hold) begin
      act_q  <= act_d;
      op_q   <= op_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) base_q <= base_d;
  end

  // R5
  sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !adv && !sel) |=> !act_q);

  // R12
  adv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && adv && !act_q) |=> !act_q);

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              in_valid,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lane_n,
  output logic              out_valid,
  output op_e               out_op,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_mask
);

  logic [LAT-1:0]    v_q;
  op_e               op_q [LAT];
  logic [ADDR_W-1:0] a_q  [LAT];
  logic [LANES-1:0]  m_q  [LAT];
  logic [LANES-1:0]  in_mask;

  // lane enables only matter for writes
  always_comb begin
    in_mask = (in_op == OP_WR) ? ~in_lane_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (!hold) begin
      for (int i = LAT - 1; i > 0; i--) v_q[i] <= v_q[i-1];
      v_q[0] <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) begin
      for (int i = LAT - 1; i > 0; i--) begin
        op_q[i] <= op_q[i-1];
        a_q[i]  <= a_q[i-1];
        m_q[i]  <= m_q[i-1];
      end
      op_q[0] <= in_op;
      a_q[0]  <= in_addr;
      m_q[0]  <= in_mask;
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_op    = op_q[LAT-1];
  assign out_addr  = a_q[LAT-1];
  assign out_mask  = m_q[LAT-1];

  // R4
  pipe_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(out_valid) && $stable(out_addr)));

  // R8
  rd_nomask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == OP_RD) |-> (out_mask == '0));

endmodule

// File: rtl/zbt_store.sv
module zbt_store
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD   = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  logic                    s_valid,
  input  op_e                     s_op,
  input  logic [ADDR_W-1:0]       s_addr,
  input  logic [WORD/LANE_W-1:0]  s_mask,
  input  logic [WORD-1:0]         wdata,
  output logic [WORD-1:0]         rdata,
  output logic                    rd_vld
);

  localparam int unsigned LANES = WORD / LANE_W;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD-1:0]   mem [DEPTH];

  logic              wb_valid_q, wb_valid_d;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [LANES-1:0]  wb_mask_q;
  logic [WORD-1:0]   wb_data_q;
  logic              rd_vld_q, rd_vld_d;
  logic [WORD-1:0]   rdata_q;

  logic              take_wr, take_rd, hit;
  logic [WORD-1:0]   raw, fwd;

  always_comb begin
    take_wr    = s_valid && (s_op == OP_WR);
    take_rd    = s_valid && (s_op == OP_RD);
    raw        = mem[s_addr];
    hit        = wb_valid_q && (wb_addr_q == s_addr);
    wb_valid_d = take_wr;
    rd_vld_d   = take_rd;
  end

  // merge uncommitted lanes of the write buffer into the read word
  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign fwd[l*LANE_W +: LANE_W] = (hit && wb_mask_q[l]) ?
                                     wb_data_q[l*LANE_W +: LANE_W] :
                                     raw[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid_q <= 1'b0;
      rd_vld_q   <= 1'b0;
    end else if (!hold) begin
      wb_valid_q <= wb_valid_d;
      rd_vld_q   <= rd_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) begin
      if (take_wr) begin
        wb_addr_q <= s_addr;
        wb_mask_q <= s_mask;
        wb_data_q <= wdata;
      end
      if (take_rd) rdata_q <= fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (!hold && wb_valid_q) begin
      for (int l = 0; l < LANES; l++) begin
        if (wb_mask_q[l]) mem[wb_addr_q][l*LANE_W +: LANE_W] <= wb_data_q[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata  = rdata_q;
  assign rd_vld = rd_vld_q;

  // R6
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && take_wr) |=> !rd_vld);

  // R1
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && take_rd) |=> rd_vld);

  // R4
  out_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(rd_vld) && $stable(rdata)));

  // R13
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rd_vld);

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int unsigned WORD         = 18,
  parameter int unsigned ADDR_W       = 6,
  parameter bit          LINEAR_BURST = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hold,
  input  logic                   sel0_n,
  input  logic                   sel1,
  input  logic                   sel2_n,
  input  logic                   adv,
  input  logic                   is_read,
  input  logic [WORD/LANE_W-1:0] lane_wr_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [WORD-1:0]        wdata,
  input  logic                   out_en_n,
  output logic [WORD-1:0]        rdata,
  output logic                   rdata_drv
);

  localparam int unsigned LANES = WORD / LANE_W;

  logic              sel;
  logic              iss_valid;
  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  logic              s2_valid;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_mask;
  logic              rd_vld;

  assign sel = !sel0_n && sel1 && !sel2_n;

  zbt_burst_gen #(.ADDR_W(ADDR_W), .LINEAR(LINEAR_BURST)) u_burst (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sel(sel), .adv(adv),
    .is_read(is_read), .addr(addr),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_addr(iss_addr)
  );

  zbt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LAT(2)) u_pipe (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .in_valid(iss_valid), .in_op(iss_op), .in_addr(iss_addr), .in_lane_n(lane_wr_n),
    .out_valid(s2_valid), .out_op(s2_op), .out_addr(s2_addr), .out_mask(s2_mask)
  );

  zbt_store #(.ADDR_W(ADDR_W), .WORD(WORD)) u_store (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .s_valid(s2_valid), .s_op(s2_op), .s_addr(s2_addr), .s_mask(s2_mask),
    .wdata(wdata), .rdata(rdata), .rd_vld(rd_vld)
  );

  assign rdata_drv = rd_vld && !out_en_n;

endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/100ps
module zbt_sram_tb;

  logic        clk = 1'b0;
  logic        rst_n, hold, sel0_n, sel1, sel2_n, adv, is_read, out_en_n;
  logic [1:0]  lane_wr_n;
  logic [5:0]  addr;
  logic [17:0] wdata;
  logic [17:0] rdata;
  logic        rdata_drv;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  zbt_sram u_dut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .adv(adv), .is_read(is_read), .lane_wr_n(lane_wr_n),
    .addr(addr), .wdata(wdata), .out_en_n(out_en_n),
    .rdata(rdata), .rdata_drv(rdata_drv)
  );

  typedef struct packed {
    logic        sel;
    logic        adv;
    logic        rd;
    logic [1:0]  bwn;
    logic [5:0]  ad;
    logic [17:0] wd;
    logic        ed;
    logic [17:0] er;
  } vec_t;

  localparam int NV = 24;
  // wd belongs to the write issued two rows earlier; ed/er describe the outputs after this row's edge
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b0, 2'b00, 6'd1, 18'h00000, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 1'b0, 2'b00, 6'd2, 18'h00000, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 1'b1, 2'b00, 6'd1, 18'h12345, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 1'b0, 2'b00, 6'd3, 18'h2ABCD, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 1'b1, 2'b00, 6'd2, 18'h00000, 1'b1, 18'h12345},
    '{1'b1, 1'b0, 1'b1, 2'b00, 6'd3, 18'h3C0F0, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 1'b0, 2'b00, 6'd4, 18'h00000, 1'b1, 18'h2ABCD},
    '{1'b1, 1'b0, 1'b1, 2'b00, 6'd4, 18'h00000, 1'b1, 18'h3C0F0},
    '{1'b1, 1'b0, 1'b0, 2'b10, 6'd4, 18'h15A5A, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 1'b1, 2'b00, 6'd4, 18'h00000, 1'b1, 18'h15A5A},
    '{1'b1, 1'b0, 1'b1, 2'b00, 6'd4, 18'h3FFFF, 1'b0, 18'h00000},
    '{1'b0, 1'b0, 1'b1, 2'b00, 6'd4, 18'h00000, 1'b1, 18'h15BFF},
    '{1'b0, 1'b1, 1'b1, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h15BFF},
    '{1'b1, 1'b0, 1'b0, 2'b00, 6'd6, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, 1'b1, 1'b0, 2'b00, 6'd0, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, 1'b1, 1'b0, 2'b00, 6'd0, 18'h00111, 1'b0, 18'h00000},
    '{1'b0, 1'b1, 1'b0, 2'b00, 6'd0, 18'h00222, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 1'b1, 2'b00, 6'd5, 18'h00333, 1'b0, 18'h00000},
    '{1'b0, 1'b1, 1'b1, 2'b00, 6'd0, 18'h00444, 1'b0, 18'h00000},
    '{1'b0, 1'b1, 1'b1, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h00444},
    '{1'b0, 1'b1, 1'b1, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h00111},
    '{1'b0, 1'b0, 1'b1, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h00222},
    '{1'b0, 1'b1, 1'b1, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h00333},
    '{1'b0, 1'b0, 1'b1, 2'b00, 6'd0, 18'h00000, 1'b0, 18'h00000}
  };

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic h, input logic s0n, input logic s1v, input logic s2n,
                     input logic a, input logic rd, input logic [1:0] bw,
                     input logic [5:0] ad, input logic [17:0] wd);
    @(negedge clk);
    hold = h; sel0_n = s0n; sel1 = s1v; sel2_n = s2n; adv = a; is_read = rd;
    lane_wr_n = bw; addr = ad; wdata = wd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hold = 1'b0; sel0_n = 1'b1; sel1 = 1'b0; sel2_n = 1'b1;
    adv = 1'b0; is_read = 1'b1; lane_wr_n = 2'b11; addr = '0; wdata = '0;
    out_en_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R13 drive flag in reset", {17'd0, rdata_drv}, 18'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd0, 18'd0);
    chk("R13 drive flag after reset", {17'd0, rdata_drv}, 18'd0);

    // stimulus table: R1 R2 R3 R5 R6 R7 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      cyc(1'b0, 1'b0, TBL[i].sel, 1'b0, TBL[i].adv, TBL[i].rd, TBL[i].bwn, TBL[i].ad, TBL[i].wd);
      chk($sformatf("R1 R2 R3 R6 R12 drive row %0d", i), {17'd0, rdata_drv}, {17'd0, TBL[i].ed});
      if (TBL[i].ed)
        chk($sformatf("R1 R3 R7 R10 R11 data row %0d", i), rdata, TBL[i].er);
    end

    // hold window with a write attempted inside it (R4), reads with lane enables low (R8)
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 6'd1, 18'd0);
    chk("R4 A", {17'd0, rdata_drv}, 18'd0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'd1, 18'd0);
    chk("R4 B frozen", {17'd0, rdata_drv}, 18'd0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'd1, 18'd0);
    chk("R4 C frozen", {17'd0, rdata_drv}, 18'd0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 6'd0, 18'd0);
    chk("R4 D", {17'd0, rdata_drv}, 18'd0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 6'd0, 18'd0);
    chk("R4 E resume drive", {17'd0, rdata_drv}, 18'd1);
    chk("R4 E resume data", rdata, 18'h12345);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'd9, 18'h3FFFF);
    chk("R4 F held drive", {17'd0, rdata_drv}, 18'd1);
    chk("R4 F held data", rdata, 18'h12345);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 6'd0, 18'd0);
    chk("R5 G idle", {17'd0, rdata_drv}, 18'd0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 6'd1, 18'd0);
    chk("R8 H", {17'd0, rdata_drv}, 18'd0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 6'd0, 18'd0);
    chk("R8 I", {17'd0, rdata_drv}, 18'd0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 6'd0, 18'd0);
    chk("R4 R8 J drive", {17'd0, rdata_drv}, 18'd1);
    chk("R4 R8 J data unchanged", rdata, 18'h12345);

    // asynchronous output enable (R9)
    out_en_n = 1'b1;
    #0.5;
    chk("R9 forced off", {17'd0, rdata_drv}, 18'd0);
    out_en_n = 1'b0;
    #0.2;
    chk("R9 back on", {17'd0, rdata_drv}, 18'd1);
    chk("R9 data kept", rdata, 18'h12345);

    // each chip select on its own blocks a load (R5)
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 6'd1, 18'd0);
    chk("R5 K", {17'd0, rdata_drv}, 18'd0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 6'd1, 18'd0);
    chk("R5 L", {17'd0, rdata_drv}, 18'd0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 6'd0, 18'd0);
    chk("R5 R6 sel0_n high", {17'd0, rdata_drv}, 18'd0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 6'd0, 18'd0);
    chk("R5 R6 sel2_n high", {17'd0, rdata_drv}, 18'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule